// File: doc/BRIEF.md
# Coherent Byte-Access Channel Value Register Bank

This block holds the 16-bit value register of each timer channel behind an 8-bit register bus. A 16-bit quantity cannot be moved in one bus cycle, so the block adds buffering. Software always sees, or changes, both halves of one value together. It accepts either byte order.

Each channel runs in one of two modes.

- **Input mode.** A capture strobe loads the register from the capture path. The first byte read snapshots the whole value into a read buffer. Later reads are served from that snapshot until the opposite byte has been read.
- **Output mode.** Byte writes collect in a write buffer. The full value moves into the active compare register on the next update strobe once both bytes are present.

A debug-halt input freezes both coherency state machines. During halt, reads and writes go straight to the live register. Any half-finished sequence survives the halt and can be completed afterwards.

The bus is a plain register port with single-cycle strobes and no back-pressure. Read data is combinational from the address and read strobe. The capture and update strobes are one-cycle pulses with no handshake. Each channel occupies three consecutive byte addresses starting at `CH_BASE`:

| Offset | Byte |
|---|---|
| +0 | status/control |
| +1 | value high byte |
| +2 | value low byte |

Top module: `chval_bank`

## Requirements
- R1: After reset every channel value is 0x0000, and every byte read returns 0x00.
- R2: In output mode (`ch_out[i]`=1), once both value bytes have been written in either order, the next `upd_stb` pulse (with halt low) loads the buffered 16-bit value into `ch_val` one clock later. Value-byte reads in output mode return the active value directly.
- R3: In output mode, `ch_val` does not change without `upd_stb`. An update strobe arriving while only one byte has been written commits nothing, and that byte stays pending.
- R4: A write to a channel's status/control byte while `mod_en`=0 discards that channel's partly written value. While `mod_en`=1 such a write leaves the pending bytes intact.
- R5: In input mode (`ch_out[i]`=0), bus writes to the value bytes and update strobes have no effect on `ch_val`.
- R6: In input mode, a `cap_stb[i]` pulse loads `cap_val` slice i into `ch_val` one clock later.
- R7: In input mode, with halt low and the latch free, reading either value byte returns the live byte and snapshots the full value. Re-reading the same byte returns the snapshot. Reading the opposite byte returns the snapshot and releases the latch.
- R8: A write to a channel's status/control byte releases that channel's read latch, whether halt is high or low.
- R9: While `dbg_halt`=1, input-mode reads return the live value and do not change the latch. After halt ends, a read sequence begun before halt continues from its snapshot.
- R10: While `dbg_halt`=1, output-mode byte writes go straight into `ch_val` and no commit occurs. A sequence pending from before halt is kept, and completing it after halt commits the bytes buffered before halt.
- R11: Channel i's status/control byte is at `CH_BASE`+3·i, its high byte at +1, and its low byte at +2. Accesses to one channel never affect another. Reads of control bytes or unmapped addresses return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address |
| bus_wr | input | 1 | Byte write strobe |
| bus_rd | input | 1 | Byte read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while `bus_rd` is high |
| ch_out | input | NUM_CH | Per channel: 1 = output compare mode, 0 = input capture mode |
| mod_en | input | 1 | Module enable bit; 0 lets a control write discard a partial value write |
| dbg_halt | input | 1 | Debug halt: freezes coherency state, bypasses buffers |
| cap_stb | input | NUM_CH | Per-channel capture load pulse |
| cap_val | input | 16·NUM_CH | Captured values, channel i at bits [16i+15:16i] |
| upd_stb | input | 1 | Commit pulse for completed write buffers |
| ch_val | output | 16·NUM_CH | Active register values, channel i at bits [16i+15:16i] |

## Verification
Some rules can be checked on every cycle and are covered by assertions:

- an input-mode value moves only on a capture strobe, and takes the captured word;
- an output-mode value holds without an update strobe;
- a halted output channel changes only by a direct byte write, which lands in that byte;
- a halted input-mode read returns the live byte.

Coherency itself depends on history: which byte was read first, which bytes are pending, and what happened before halt. Only the bench's ordered scenarios can show it. These cover both byte orders, same-byte re-reads, control-write release and discard under each enable setting, and sequences split across a halt.

// File: rtl/chval_pkg.sv
package chval_pkg;
  localparam int SLOTS_PER_CH = 3;

  typedef enum logic [1:0] {
    SLOT_CTRL = 2'd0,
    SLOT_HI   = 2'd1,
    SLOT_LO   = 2'd2
  } slot_e;

  typedef struct packed {
    logic ctrl_wr;
    logic hi_wr;
    logic lo_wr;
    logic hi_rd;
    logic lo_rd;
  } ch_access_t;
endpackage

// File: rtl/chval_addr_dec.sv
module chval_addr_dec #(
  parameter int NUM_CH  = 6,
  parameter int ADDR_W  = 8,
  parameter int CH_BASE = 5
) (
  input  logic [ADDR_W-1:0]     addr,
  input  logic                  wr,
  input  logic                  rd,
  output chval_pkg::ch_access_t acc [NUM_CH]
);
  import chval_pkg::*;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CH_BASE + SLOTS_PER_CH*i + int'(SLOT_CTRL));
    localparam logic [ADDR_W-1:0] A_HI   = ADDR_W'(CH_BASE + SLOTS_PER_CH*i + int'(SLOT_HI));
    localparam logic [ADDR_W-1:0] A_LO   = ADDR_W'(CH_BASE + SLOTS_PER_CH*i + int'(SLOT_LO));
    logic hit_ctrl, hit_hi, hit_lo;
    assign hit_ctrl = (addr == A_CTRL);
    assign hit_hi   = (addr == A_HI);
    assign hit_lo   = (addr == A_LO);
    always_comb begin
      acc[i].ctrl_wr = wr & hit_ctrl;
      acc[i].hi_wr   = wr & hit_hi;
      acc[i].lo_wr   = wr & hit_lo;
      acc[i].hi_rd   = rd & hit_hi;
      acc[i].lo_rd   = rd & hit_lo;
    end
  end
endmodule

// File: rtl/chval_rd_latch.sv
module chval_rd_latch #(
  parameter int VAL_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             halt,
  input  logic             rd_hi,
  input  logic             rd_lo,
  input  logic             clr,
  input  logic [VAL_W-1:0] live,
  output logic             held,
  output logic [VAL_W-1:0] snap
);
  logic first_hi;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held     <= 1'b0;
      first_hi <= 1'b0;
      snap     <= '0;
    end else if (clr) begin
      held <= 1'b0;
    end else if (!halt) begin
      if (!held) begin
        if (rd_hi || rd_lo) begin
          held     <= 1'b1;
          snap     <= live;
          first_hi <= rd_hi;
        end
      end else if ((first_hi && rd_lo) || (!first_hi && rd_hi)) begin
        held <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/chval_wr_buf.sv
module chval_wr_buf #(
  parameter int VAL_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             halt,
  input  logic             en_bit,
  input  logic             wr_hi,
  input  logic             wr_lo,
  input  logic [7:0]       wdata,
  input  logic             clr,
  input  logic             upd,
  output logic             commit,
  output logic [VAL_W-1:0] wbuf
);
  localparam int LO_W = VAL_W / 2;
  logic got_hi, got_lo;

  assign commit = upd & got_hi & got_lo & ~halt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      got_hi <= 1'b0;
      got_lo <= 1'b0;
      wbuf   <= '0;
    end else if (clr && !en_bit) begin
      got_hi <= 1'b0;
      got_lo <= 1'b0;
    end else begin
      if (commit) begin
        got_hi <= 1'b0;
        got_lo <= 1'b0;
      end
      if (!halt) begin
        if (wr_hi) begin
          wbuf[VAL_W-1:LO_W] <= wdata;
          got_hi             <= 1'b1;
        end
        if (wr_lo) begin
          wbuf[LO_W-1:0] <= wdata;
          got_lo         <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/chval_channel.sv
module chval_channel #(
  parameter int VAL_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  chval_pkg::ch_access_t acc,
  input  logic                  is_out,
  input  logic                  en_bit,
  input  logic                  halt,
  input  logic                  cap_stb,
  input  logic [VAL_W-1:0]      cap_val,
  input  logic                  upd,
  input  logic [7:0]            wdata,
  output logic [VAL_W-1:0]      val,
  output logic [7:0]            rdata
);
  localparam int LO_W = VAL_W / 2;

  logic             held, commit;
  logic [VAL_W-1:0] snap, wbuf, src;

  chval_rd_latch #(.VAL_W(VAL_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .halt(halt),
    .rd_hi(acc.hi_rd & ~is_out), .rd_lo(acc.lo_rd & ~is_out),
    .clr(acc.ctrl_wr), .live(val), .held(held), .snap(snap)
  );

  chval_wr_buf #(.VAL_W(VAL_W)) u_wr (
    .clk(clk), .rst_n(rst_n), .halt(halt), .en_bit(en_bit),
    .wr_hi(acc.hi_wr & is_out), .wr_lo(acc.lo_wr & is_out),
    .wdata(wdata), .clr(acc.ctrl_wr), .upd(upd),
    .commit(commit), .wbuf(wbuf)
  );

  assign src = (!is_out && held && !halt) ? snap : val;

  always_comb begin
    if (acc.hi_rd)      rdata = src[VAL_W-1:LO_W];
    else if (acc.lo_rd) rdata = src[LO_W-1:0];
    else                rdata = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      val <= '0;
    end else if (!is_out) begin
      if (cap_stb) val <= cap_val;
    end else if (commit) begin
      val <= wbuf;
    end else if (halt) begin
      if (acc.hi_wr) val[VAL_W-1:LO_W] <= wdata;
      if (acc.lo_wr) val[LO_W-1:0]     <= wdata;
    end
  end
endmodule

// File: rtl/chval_bank.sv
module chval_bank #(
  parameter int NUM_CH  = 6,
  parameter int ADDR_W  = 8,
  parameter int CH_BASE = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [7:0]           bus_wdata,
  output logic [7:0]           bus_rdata,
  input  logic [NUM_CH-1:0]    ch_out,
  input  logic                 mod_en,
  input  logic                 dbg_halt,
  input  logic [NUM_CH-1:0]    cap_stb,
  input  logic [NUM_CH*16-1:0] cap_val,
  input  logic                 upd_stb,
  output logic [NUM_CH*16-1:0] ch_val
);
  localparam int VAL_W = 16;

  chval_pkg::ch_access_t acc [NUM_CH];
  logic [7:0]            ch_rdata [NUM_CH];

  chval_addr_dec #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .CH_BASE(CH_BASE)) u_dec (
    .addr(bus_addr), .wr(bus_wr), .rd(bus_rd), .acc(acc)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    chval_channel #(.VAL_W(VAL_W)) u_ch (
      .clk(clk), .rst_n(rst_n), .acc(acc[i]), .is_out(ch_out[i]),
      .en_bit(mod_en), .halt(dbg_halt), .cap_stb(cap_stb[i]),
      .cap_val(cap_val[i*VAL_W +: VAL_W]), .upd(upd_stb), .wdata(bus_wdata),
      .val(ch_val[i*VAL_W +: VAL_W]), .rdata(ch_rdata[i])
    );
  end

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NUM_CH; i++) bus_rdata = bus_rdata | ch_rdata[i];
  end
endmodule

// File: rtl/chval_bank_chk.sv
module chval_bank_chk #(
  parameter int NUM_CH  = 6,
  parameter int ADDR_W  = 8,
  parameter int CH_BASE = 5
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [ADDR_W-1:0]    bus_addr,
  input logic                 bus_wr,
  input logic                 bus_rd,
  input logic [7:0]           bus_wdata,
  input logic [7:0]           bus_rdata,
  input logic [NUM_CH-1:0]    ch_out,
  input logic                 dbg_halt,
  input logic [NUM_CH-1:0]    cap_stb,
  input logic [NUM_CH*16-1:0] cap_val,
  input logic                 upd_stb,
  input logic [NUM_CH*16-1:0] ch_val
);
  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    localparam logic [ADDR_W-1:0] A_HI = ADDR_W'(CH_BASE + 3*i + 1);
    localparam logic [ADDR_W-1:0] A_LO = ADDR_W'(CH_BASE + 3*i + 2);

    a_r5_input_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!ch_out[i] && !cap_stb[i]) |=> $stable(ch_val[i*16 +: 16]));

    a_r6_capture_load: assert property (@(posedge clk) disable iff (!rst_n)
      (!ch_out[i] && cap_stb[i]) |=> ch_val[i*16 +: 16] == $past(cap_val[i*16 +: 16]));

    a_r3_output_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_out[i] && !upd_stb && !dbg_halt) |=> $stable(ch_val[i*16 +: 16]));

    a_r10_halt_write_hi: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_out[i] && dbg_halt && bus_wr && bus_addr == A_HI)
        |=> ch_val[i*16+8 +: 8] == $past(bus_wdata));

    a_r10_halt_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_out[i] && dbg_halt && !(bus_wr && (bus_addr == A_HI || bus_addr == A_LO)))
        |=> $stable(ch_val[i*16 +: 16]));

    a_r9_halt_live_read: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && dbg_halt && !ch_out[i] && bus_addr == A_HI)
        |-> bus_rdata == ch_val[i*16+8 +: 8]);
  end
endmodule

bind chval_bank chval_bank_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .CH_BASE(CH_BASE)) u_chk (.*);

// File: tb/chval_bank_bench.sv
module chval_bank_bench;
  localparam int NCH  = 2;
  localparam int AW   = 8;
  localparam int BASE = 16;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic              rst_n = 1'b0;
  logic [AW-1:0]     bus_addr = '0;
  logic              bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]        bus_wdata = '0, bus_rdata;
  logic [NCH-1:0]    ch_out = '1;
  logic              mod_en = 1'b0, dbg_halt = 1'b0, upd_stb = 1'b0;
  logic [NCH-1:0]    cap_stb = '0;
  logic [NCH*16-1:0] cap_val = '0, ch_val;

  chval_bank #(.NUM_CH(NCH), .ADDR_W(AW), .CH_BASE(BASE)) u_chval_bank (.*);

  int n_vec = 0, n_bad = 0;

  function automatic logic [AW-1:0] a_ctl(int ch); return AW'(BASE + 3*ch);     endfunction
  function automatic logic [AW-1:0] a_hi(int ch);  return AW'(BASE + 3*ch + 1); endfunction
  function automatic logic [AW-1:0] a_lo(int ch);  return AW'(BASE + 3*ch + 2); endfunction
  function automatic logic [15:0] val_of(int ch);  return ch_val[ch*16 +: 16];  endfunction

  task automatic chk(string rq, logic [15:0] act, logic [15:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic upd();
    @(negedge clk); upd_stb = 1'b1;
    @(negedge clk); upd_stb = 1'b0;
  endtask

  task automatic cap(int ch, logic [15:0] v);
    @(negedge clk); cap_val[ch*16 +: 16] = v; cap_stb[ch] = 1'b1;
    @(negedge clk); cap_stb[ch] = 1'b0;
  endtask

  task automatic rdchk(string rq, logic [AW-1:0] a, logic [7:0] exp);
    logic [7:0] d;
    rd(a, d);
    chk(rq, {8'h00, d}, {8'h00, exp});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] last [NCH];
    logic [15:0] a, b;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state, R11 control and unmapped reads
    for (int c = 0; c < NCH; c++) begin
      chk("R1 value", val_of(c), 16'h0);
      rdchk("R1 hi read", a_hi(c), 8'h00);
      rdchk("R1 lo read", a_lo(c), 8'h00);
      rdchk("R11 ctrl read", a_ctl(c), 8'h00);
      last[c] = 16'h0;
    end
    rdchk("R11 unmapped read", 8'h00, 8'h00);

    // R2/R3 output sweep: both byte orders, commit only on strobe
    for (int c = 0; c < NCH; c++)
      for (int ord = 0; ord < 2; ord++)
        for (int k = 0; k < 16; k++) begin
          logic [15:0] v;
          v = 16'(k*4369 + c*257 + ord*3 + 1);
          if (ord == 0) begin wr(a_hi(c), v[15:8]); wr(a_lo(c), v[7:0]); end
          else          begin wr(a_lo(c), v[7:0]);  wr(a_hi(c), v[15:8]); end
          chk("R3 no commit before strobe", val_of(c), last[c]);
          upd();
          chk("R2 commit", val_of(c), v);
          chk("R11 other channel untouched", val_of(1-c), last[1-c]);
          rdchk("R2 output read hi", a_hi(c), v[15:8]);
          rdchk("R2 output read lo", a_lo(c), v[7:0]);
          last[c] = v;
        end

    // R3 partial write with strobe
    wr(a_hi(0), 8'hAA); upd();
    chk("R3 partial no commit", val_of(0), last[0]);
    wr(a_lo(0), 8'h55); upd();
    chk("R3 completed commit", val_of(0), 16'hAA55);

    // R4 control write discards only when enable low
    mod_en = 1'b0;
    wr(a_hi(0), 8'h11); wr(a_ctl(0), 8'h00); wr(a_lo(0), 8'h22); upd();
    chk("R4 discard en=0", val_of(0), 16'hAA55);
    wr(a_hi(0), 8'h33); upd();
    chk("R4 restart after discard", val_of(0), 16'h3322);
    mod_en = 1'b1;
    wr(a_hi(0), 8'h44); wr(a_ctl(0), 8'h00); wr(a_lo(0), 8'h66); upd();
    chk("R4 keep en=1", val_of(0), 16'h4466);
    mod_en = 1'b0;

    // R5/R6/R7 input sweep
    ch_out = '0;
    for (int c = 0; c < NCH; c++)
      for (int k = 0; k < 8; k++) begin
        logic [AW-1:0] f, o;
        logic [15:0] p, q;
        a = 16'(k*7919 + c*31 + 5);
        b = ~a;
        cap(c, a);
        chk("R6 capture load", val_of(c), a);
        wr(a_hi(c), 8'hFF); wr(a_lo(c), 8'hEE); upd();
        chk("R5 input writes ignored", val_of(c), a);
        f = k[0] ? a_lo(c) : a_hi(c);
        o = k[0] ? a_hi(c) : a_lo(c);
        p = k[0] ? {8'h00, a[7:0]} : {8'h00, a[15:8]};
        q = k[0] ? {8'h00, a[15:8]} : {8'h00, a[7:0]};
        rdchk("R7 first read live", f, p[7:0]);
        cap(c, b);
        rdchk("R7 same byte buffered", f, p[7:0]);
        rdchk("R7 opposite byte buffered", o, q[7:0]);
        p = k[0] ? {8'h00, b[7:0]} : {8'h00, b[15:8]};
        q = k[0] ? {8'h00, b[15:8]} : {8'h00, b[7:0]};
        rdchk("R7 released new latch", o, q[7:0]);
        rdchk("R7 second pair", f, p[7:0]);
      end

    // R8 control write releases latch during halt
    cap(0, 16'hC1C2); rdchk("R8 latch", a_hi(0), 8'hC1);
    cap(0, 16'hD1D2);
    dbg_halt = 1'b1; wr(a_ctl(0), 8'h00); dbg_halt = 1'b0;
    rdchk("R8 released lo", a_lo(0), 8'hD2);
    rdchk("R8 released hi", a_hi(0), 8'hD1);

    // R9 halt reads live, latch frozen
    cap(0, 16'hE1E2); rdchk("R9 latch", a_hi(0), 8'hE1);
    cap(0, 16'hF1F2);
    dbg_halt = 1'b1;
    rdchk("R9 halt live lo", a_lo(0), 8'hF2);
    rdchk("R9 halt live hi", a_hi(0), 8'hF1);
    dbg_halt = 1'b0;
    rdchk("R9 resume snapshot", a_lo(0), 8'hE2);
    rdchk("R9 after release", a_hi(0), 8'hF1);
    rdchk("R9 after release lo", a_lo(0), 8'hF2);

    // R10 halt writes direct, pending sequence preserved
    ch_out = '1;
    wr(a_hi(1), 8'h12);
    dbg_halt = 1'b1;
    wr(a_hi(1), 8'hAB); wr(a_lo(1), 8'hCD);
    chk("R10 direct write", val_of(1), 16'hABCD);
    upd();
    chk("R10 no commit in halt", val_of(1), 16'hABCD);
    dbg_halt = 1'b0;
    wr(a_lo(1), 8'h34);
    chk("R10 pending not yet committed", val_of(1), 16'hABCD);
    upd();
    chk("R10 pre-halt bytes commit", val_of(1), 16'h1234);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule